// File: doc/BRIEF.md
# Strided Scratchpad DMA Engine

This block moves bytes between an external main memory and two 4 KiB on-chip scratchpads, one holding instructions and one holding data. A transfer covers a rectangle: a number of rows, each row of equal length, with an extra skip added to the main-memory address after every row. The scratchpad side runs on contiguously. One 32-bit length word packs all three shape values. The row length is always rounded up to a whole multiple of eight bytes.

Software first loads a scratchpad address register and a main-memory address register. It then writes a length word to one of two length selectors. The selector it uses decides the direction: main memory into scratchpad, or scratchpad out to main memory. The engine moves one byte per cycle through a short fixed pipeline. It holds `busy` for the whole transfer and pulses `done` once when the last byte is written. A separate byte-wide core port reaches both scratchpads at any time through the second port of each memory.

Top module: `sdma_engine`

## Requirements
- R1: The length word holds three fields. Bits [11:0] are the column field F, bits [19:12] are the row field RF and bits [31:20] are the skip S. A row carries (F | 7) + 1 bytes and there are RF + 1 rows, so N = ((F | 7) + 1) * (RF + 1) bytes move and no more.
- R2: The main-memory logical address starts at the low 24 bits of the main address register. It rises by 1 within a row. After the last byte of a row it rises by 1 + S. Arithmetic is modulo 2^24.
- R3: The scratchpad logical address starts at bits [11:0] of the scratchpad address register. It rises by 1 for every byte, across row boundaries, and wraps modulo 4096.
- R4: Bit 12 of the scratchpad address register picks the bank: 1 selects the instruction bank (core-port bank 1) and 0 selects the data bank (bank 0). The other bank is never touched.
- R5: `reg_sel` encodes the target of a write: 0 = scratchpad address, 1 = main address, 2 = inbound length (main memory to scratchpad, uses only `mm_rd`), 3 = outbound length (scratchpad to main memory, uses only `mm_wr`).
- R6: Byte lanes are swapped on both sides. The physical address is the logical address XOR 3, both on `mm_addr` and in the scratchpad array. The core port uses physical scratchpad addresses.
- R7: Say the accepting length write is sampled at rising edge E. Then `busy` is high from E up to edge E+N+2. `done` is high for exactly the one cycle between edges E+N+2 and E+N+3. Exactly N main-memory strobes are issued, one per cycle.
- R8: A length write while `busy` is high is ignored. It changes neither the running transfer nor starts a later one.
- R9: After reset `busy`, `done`, `mm_rd` and `mm_wr` are low. With `busy` low, neither strobe is ever asserted.
- R10: A core-port access with `cp_en` high is sampled at an edge. A write stores `cp_wdata`. `cp_rdata` presents the addressed byte of bank `cp_bank` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (see R5) |
| reg_wdata | input | 32 | Register write data |
| mm_addr | output | 24 | Main-memory physical byte address |
| mm_rd | output | 1 | Main-memory read strobe; data expected on `mm_rdata` one cycle later |
| mm_rdata | input | 8 | Main-memory read data |
| mm_wr | output | 1 | Main-memory write strobe |
| mm_wdata | output | 8 | Main-memory write data |
| cp_en | input | 1 | Core-port access enable |
| cp_we | input | 1 | Core-port write enable |
| cp_bank | input | 1 | Core-port bank (1 instruction, 0 data) |
| cp_addr | input | 12 | Core-port physical scratchpad address |
| cp_wdata | input | 8 | Core-port write data |
| cp_rdata | output | 8 | Core-port read data, one cycle after the access |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last byte is written |

## Verification
Every transfer has a fixed end time. The last byte lands at edge E+N+2, so `done` and the final write are both due N+2 edges after the accepting edge. The bench counts rising edges from that edge, samples on falling edges, and requires `done` on exactly that count with `busy` dropping at the same moment. Scratchpad contents are read back only after `done`, through the core port, whose one-cycle read latency the read task waits out. Main-memory results are checked in the bench's own memory model, which the engine writes at edge E+N+2 at the latest.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  // register selector codes
  typedef enum logic [1:0] {
    SEL_SPAD   = 2'd0,
    SEL_MAIN   = 2'd1,
    SEL_GO_IN  = 2'd2,
    SEL_GO_OUT = 2'd3
  } sdma_sel_e;

  localparam int NBANK   = 2;   // data bank 0, instruction bank 1
  localparam int BYTE_W  = 8;
  localparam int ROUND_M = 7;   // row length rounded up to multiple of ROUND_M+1
  localparam int LANE_X  = 3;   // byte-lane swap applied to physical addresses
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int SP_AW  = 12,
  parameter int MM_AW  = 24,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 8,
  parameter int SKIP_W = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_we,
  input  logic [1:0]                      reg_sel,
  input  logic [COL_W+ROW_W+SKIP_W-1:0]   reg_wdata,
  input  logic                            engine_busy,
  output logic                            start,
  output logic                            start_in,
  output logic                            start_bank,
  output logic [SP_AW-1:0]                sp_base,
  output logic [MM_AW-1:0]                mm_base,
  output logic [COL_W-1:0]                col_last,
  output logic [ROW_W-1:0]                row_last,
  output logic [SKIP_W-1:0]               skip
);
  localparam int ROW_LSB  = COL_W;
  localparam int SKIP_LSB = COL_W + ROW_W;

  logic [SP_AW:0]    sp_reg;
  logic [MM_AW-1:0]  mm_reg;
  logic              is_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_reg <= '0;
      mm_reg <= '0;
    end else if (reg_we) begin
      if (reg_sel == SEL_SPAD) sp_reg <= reg_wdata[SP_AW:0];
      if (reg_sel == SEL_MAIN) mm_reg <= reg_wdata[MM_AW-1:0];
    end
  end

  always_comb begin
    is_len     = (reg_sel == SEL_GO_IN) || (reg_sel == SEL_GO_OUT);
    start      = reg_we && is_len && !engine_busy;
    start_in   = (reg_sel == SEL_GO_IN);
    start_bank = sp_reg[SP_AW];
    sp_base    = sp_reg[SP_AW-1:0];
    mm_base    = mm_reg;
    col_last   = reg_wdata[COL_W-1:0] | COL_W'(ROUND_M);
    row_last   = reg_wdata[ROW_LSB +: ROW_W];
    skip       = reg_wdata[SKIP_LSB +: SKIP_W];
  end
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq #(
  parameter int SP_AW  = 12,
  parameter int MM_AW  = 24,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 8,
  parameter int SKIP_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_in,
  input  logic               start_bank,
  input  logic [SP_AW-1:0]   sp_base,
  input  logic [MM_AW-1:0]   mm_base,
  input  logic [COL_W-1:0]   col_last,
  input  logic [ROW_W-1:0]   row_last,
  input  logic [SKIP_W-1:0]  skip,
  output logic               beat_v,
  output logic               beat_last,
  output logic [SP_AW-1:0]   beat_sp,
  output logic [MM_AW-1:0]   beat_mm,
  output logic               x_in,
  output logic               x_bank
);
  logic              run;
  logic [COL_W-1:0]  col, col_end;
  logic [ROW_W-1:0]  row, row_end;
  logic [SKIP_W-1:0] skip_r;
  logic [SP_AW-1:0]  sp;
  logic [MM_AW-1:0]  mm;
  logic              row_done;

  assign row_done = (col == col_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      x_in    <= 1'b0;
      x_bank  <= 1'b0;
      col     <= '0;
      row     <= '0;
      col_end <= '0;
      row_end <= '0;
      skip_r  <= '0;
      sp      <= '0;
      mm      <= '0;
    end else if (start) begin
      run     <= 1'b1;
      x_in    <= start_in;
      x_bank  <= start_bank;
      col     <= '0;
      row     <= '0;
      col_end <= col_last;
      row_end <= row_last;
      skip_r  <= skip;
      sp      <= sp_base;
      mm      <= mm_base;
    end else if (run) begin
      sp <= sp + SP_AW'(1);
      if (row_done) begin
        col <= '0;
        mm  <= mm + MM_AW'(skip_r) + MM_AW'(1);
        if (row == row_end) run <= 1'b0;
        else                row <= row + ROW_W'(1);
      end else begin
        col <= col + COL_W'(1);
        mm  <= mm + MM_AW'(1);
      end
    end
  end

  always_comb begin
    beat_v    = run;
    beat_last = run && row_done && (row == row_end);
    beat_sp   = sp;
    beat_mm   = mm;
  end
endmodule

// File: rtl/sdma_spad_bank.sv
module sdma_spad_bank #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int SP_AW  = 12,
  parameter int MM_AW  = 24,
  parameter int COL_W  = 12,
  parameter int ROW_W  = 8,
  parameter int SKIP_W = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_we,
  input  logic [1:0]                     reg_sel,
  input  logic [COL_W+ROW_W+SKIP_W-1:0]  reg_wdata,
  output logic [MM_AW-1:0]               mm_addr,
  output logic                           mm_rd,
  input  logic [BYTE_W-1:0]              mm_rdata,
  output logic                           mm_wr,
  output logic [BYTE_W-1:0]              mm_wdata,
  input  logic                           cp_en,
  input  logic                           cp_we,
  input  logic                           cp_bank,
  input  logic [SP_AW-1:0]               cp_addr,
  input  logic [BYTE_W-1:0]              cp_wdata,
  output logic [BYTE_W-1:0]              cp_rdata,
  output logic                           busy,
  output logic                           done
);
  localparam logic [SP_AW-1:0] SP_SWAP = SP_AW'(LANE_X);
  localparam logic [MM_AW-1:0] MM_SWAP = MM_AW'(LANE_X);

  // ---- configuration and sequencing ----
  logic              start, start_in, start_bank;
  logic [SP_AW-1:0]  sp_base;
  logic [MM_AW-1:0]  mm_base;
  logic [COL_W-1:0]  col_last;
  logic [ROW_W-1:0]  row_last;
  logic [SKIP_W-1:0] skip;
  logic              beat_v, beat_last, x_in, x_bank;
  logic [SP_AW-1:0]  beat_sp;
  logic [MM_AW-1:0]  beat_mm;
  logic              busy_q, done_q;

  sdma_regs #(.SP_AW(SP_AW), .MM_AW(MM_AW), .COL_W(COL_W), .ROW_W(ROW_W), .SKIP_W(SKIP_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .engine_busy(busy_q), .start(start), .start_in(start_in), .start_bank(start_bank),
    .sp_base(sp_base), .mm_base(mm_base), .col_last(col_last), .row_last(row_last), .skip(skip)
  );

  sdma_seq #(.SP_AW(SP_AW), .MM_AW(MM_AW), .COL_W(COL_W), .ROW_W(ROW_W), .SKIP_W(SKIP_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_in(start_in), .start_bank(start_bank),
    .sp_base(sp_base), .mm_base(mm_base), .col_last(col_last), .row_last(row_last), .skip(skip),
    .beat_v(beat_v), .beat_last(beat_last), .beat_sp(beat_sp), .beat_mm(beat_mm),
    .x_in(x_in), .x_bank(x_bank)
  );

  // ---- pipeline: stage A after the beat, stage B for inbound write ----
  logic              a_v, a_last, b_v, b_last, o_last;
  logic [SP_AW-1:0]  a_sp, b_sp;
  logic [MM_AW-1:0]  a_mm;
  logic              mm_rd_q, mm_wr_q;
  logic [MM_AW-1:0]  mm_addr_q;
  logic [BYTE_W-1:0] mm_wdata_q;
  logic              fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v     <= 1'b0;
      b_v     <= 1'b0;
      mm_rd_q <= 1'b0;
      mm_wr_q <= 1'b0;
      a_last  <= 1'b0;
      b_last  <= 1'b0;
      o_last  <= 1'b0;
    end else begin
      a_v     <= beat_v;
      a_last  <= beat_last;
      b_v     <= a_v && x_in;
      b_last  <= a_last;
      mm_rd_q <= beat_v && x_in;
      mm_wr_q <= a_v && !x_in;
      o_last  <= a_last;
    end
  end

  logic [BYTE_W-1:0] dma_q [NBANK];
  logic [BYTE_W-1:0] core_q [NBANK];
  logic              cp_bank_q;

  always_ff @(posedge clk) begin
    a_sp <= beat_sp;
    a_mm <= beat_mm;
    b_sp <= a_sp;
    mm_wdata_q <= dma_q[x_bank];
    if (beat_v && x_in)       mm_addr_q <= beat_mm ^ MM_SWAP;
    else if (a_v && !x_in)    mm_addr_q <= a_mm ^ MM_SWAP;
    if (cp_en) cp_bank_q <= cp_bank;
  end

  assign fin = x_in ? (b_v && b_last) : (mm_wr_q && o_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (start)    busy_q <= 1'b1;
      else if (fin) busy_q <= 1'b0;
    end
  end

  // ---- scratchpad banks ----
  logic              dma_rd, dma_wr;
  logic [SP_AW-1:0]  dma_addr;

  always_comb begin
    dma_rd   = beat_v && !x_in;
    dma_wr   = b_v;
    dma_addr = (x_in ? b_sp : beat_sp) ^ SP_SWAP;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit_dma, hit_core;
    assign hit_dma  = (x_bank == 1'(g));
    assign hit_core = (cp_bank == 1'(g));

    sdma_spad_bank #(.AW(SP_AW), .DW(BYTE_W)) u_mem (
      .clk(clk),
      .a_en((dma_rd || dma_wr) && hit_dma), .a_we(dma_wr), .a_addr(dma_addr),
      .a_wdata(mm_rdata), .a_rdata(dma_q[g]),
      .b_en(cp_en && hit_core), .b_we(cp_we), .b_addr(cp_addr),
      .b_wdata(cp_wdata), .b_rdata(core_q[g])
    );
  end

  assign mm_addr  = mm_addr_q;
  assign mm_rd    = mm_rd_q;
  assign mm_wr    = mm_wr_q;
  assign mm_wdata = mm_wdata_q;
  assign cp_rdata = core_q[cp_bank_q];
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int MM_AW  = 24,
  parameter int SKIP_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [SKIP_W-1:0] wskip,
  input logic [MM_AW-1:0]  mm_addr,
  input logic              mm_rd,
  input logic              mm_wr,
  input logic              busy,
  input logic              done
);
  localparam logic [MM_AW-1:0] SWAP = MM_AW'(3);

  logic              cap_in, prev_v;
  logic [SKIP_W-1:0] cap_skip;
  logic [MM_AW-1:0]  prev_log, step;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_in   <= 1'b0;
      cap_skip <= '0;
      prev_v   <= 1'b0;
      prev_log <= '0;
    end else begin
      if (reg_we && reg_sel[1] && !busy) begin
        cap_in   <= !reg_sel[0];
        cap_skip <= wskip;
      end
      prev_v   <= mm_rd || mm_wr;
      prev_log <= mm_addr ^ SWAP;
    end
  end

  assign step = (mm_addr ^ SWAP) - prev_log;

  // R7: done lasts one cycle and closes busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_closes_r7: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));
  // R5: strobes match the selected direction
  p_rd_inbound_r5: assert property (@(posedge clk) disable iff (rst) mm_rd |-> (busy && cap_in && !mm_wr));
  p_wr_outbound_r5: assert property (@(posedge clk) disable iff (rst) mm_wr |-> (busy && !cap_in));
  // R9: idle engine is silent
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mm_rd && !mm_wr));
  // R2: consecutive main-memory strobes step by one or by one plus skip
  p_stride_r2: assert property (@(posedge clk) disable iff (rst)
    ((mm_rd || mm_wr) && prev_v) |-> ((step == MM_AW'(1)) || (step == MM_AW'(cap_skip) + MM_AW'(1))));
endmodule

bind sdma_engine sdma_engine_chk #(.MM_AW(MM_AW), .SKIP_W(SKIP_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
  .wskip(reg_wdata[COL_W+ROW_W +: SKIP_W]),
  .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr), .busy(busy), .done(done)
);

// File: tb/sdma_engine_bench.sv
module sdma_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [23:0] mm_addr;
  logic        mm_rd, mm_wr;
  logic [7:0]  mm_rdata = '0;
  logic [7:0]  mm_wdata;
  logic        cp_en = 1'b0, cp_we = 1'b0, cp_bank = 1'b0;
  logic [11:0] cp_addr = '0;
  logic [7:0]  cp_wdata = '0;
  logic [7:0]  cp_rdata;
  logic        busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_engine u_sdma_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_rdata(mm_rdata), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
    .cp_en(cp_en), .cp_we(cp_we), .cp_bank(cp_bank), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .busy(busy), .done(done)
  );

  // ---- main memory model (physical addresses) ----
  logic [7:0] mm_mem [int];
  logic [7:0] sh [2][4096];
  logic [7:0] gap_old [256];

  function automatic logic [7:0] mm_init(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] mm_peek(int a);
    if (mm_mem.exists(a)) return mm_mem[a];
    return mm_init(a);
  endfunction

  always @(posedge clk) begin
    if (mm_rd) mm_rdata <= mm_peek(int'(mm_addr));
    if (mm_wr) mm_mem[int'(mm_addr)] = mm_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // all tasks begin and end at a falling edge
  task automatic cp_write(input bit b, input int a, input logic [7:0] d);
    cp_en = 1'b1; cp_we = 1'b1; cp_bank = b; cp_addr = 12'(a); cp_wdata = d;
    @(posedge clk); @(negedge clk);
    cp_en = 1'b0; cp_we = 1'b0;
  endtask

  task automatic cp_read(input bit b, input int a, output logic [7:0] d);
    cp_en = 1'b1; cp_we = 1'b0; cp_bank = b; cp_addr = 12'(a);
    @(posedge clk); @(negedge clk);
    d = cp_rdata;
    cp_en = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_xfer(input bit inb, input bit bank, input int sp0, input int mm0,
                          input int f, input int rf, input int sk, input bit inject);
    int len, nb, k, done_k, rd_n, wr_n, stride, quiet;
    bit busy_ok;
    logic [7:0] v;
    len    = (f | 7) + 1;
    nb     = len * (rf + 1);
    stride = len + sk;
    reg_write(2'd0, {19'd0, bank, 12'(sp0)});
    reg_write(2'd1, {8'd0, 24'(mm0)});
    if (!inb)
      for (int r = 0; r <= rf; r++)
        gap_old[r] = mm_peek(((mm0 + r*stride + len) & 24'hFFFFFF) ^ 3);
    reg_we = 1'b1; reg_sel = inb ? 2'd2 : 2'd3;
    reg_wdata = {12'(sk), 8'(rf), 12'(f)};
    k = 0; done_k = -1; rd_n = 0; wr_n = 0; busy_ok = 1;
    while (k < nb + 40) begin
      @(posedge clk); k++;
      @(negedge clk);
      reg_we = 1'b0;
      if (inject && k == 3) begin
        reg_we = 1'b1; reg_sel = inb ? 2'd3 : 2'd2; reg_wdata = 32'h0010_2010;
      end
      if (mm_rd) rd_n++;
      if (mm_wr) wr_n++;
      if (done) begin done_k = k; break; end
      if (!busy) busy_ok = 0;
    end
    reg_we = 1'b0;
    chk(done_k == nb + 3, "R7", "done edge count", done_k, nb + 3);
    chk(busy_ok && !busy, "R7", "busy window", busy, 0);
    chk(inb ? (rd_n == nb && wr_n == 0) : (wr_n == nb && rd_n == 0), "R5", "strobe counts",
        inb ? rd_n : wr_n, nb);
    @(posedge clk); @(negedge clk);
    chk(!done, "R7", "done single cycle", done, 0);
    if (inject) begin
      quiet = 1;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); @(negedge clk);
        if (busy || done || mm_rd || mm_wr) quiet = 0;
      end
      chk(quiet == 1, "R8", "no restart from length write while busy", quiet, 1);
    end
    // content checks
    for (int r = 0; r <= rf; r++) begin
      for (int c = 0; c < len; c++) begin
        int kk, spl, mml;
        kk  = r*len + c;
        spl = (sp0 + kk) & 12'hFFF;
        mml = (mm0 + r*stride + c) & 24'hFFFFFF;
        if (inb) begin
          sh[bank][spl ^ 3] = mm_peek(mml ^ 3);
          cp_read(bank, spl ^ 3, v);
          chk(v == sh[bank][spl ^ 3], "R2/R3/R6", "scratchpad byte", v, sh[bank][spl ^ 3]);
          cp_read(!bank, spl ^ 3, v);
          chk(v == sh[!bank][spl ^ 3], "R4", "other bank untouched", v, sh[!bank][spl ^ 3]);
        end else begin
          v = mm_peek(mml ^ 3);
          chk(v == sh[bank][spl ^ 3], "R2/R3/R6", "main memory byte", v, sh[bank][spl ^ 3]);
        end
      end
      if (!inb && sk > 0) begin
        v = mm_peek(((mm0 + r*stride + len) & 24'hFFFFFF) ^ 3);
        chk(v == gap_old[r], "R2", "skip gap untouched", v, gap_old[r]);
      end
    end
    if (inb) begin
      int spn;
      spn = (sp0 + nb) & 12'hFFF;
      cp_read(bank, spn ^ 3, v);
      chk(v == sh[bank][spn ^ 3], "R1", "byte after last row untouched", v, sh[bank][spn ^ 3]);
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !mm_rd && !mm_wr, "R9", "idle after reset",
        {busy, done, mm_rd, mm_wr}, 0);
    // preload both banks through the core port
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 4096; a++) begin
        sh[b][a] = 8'(a * 7) ^ 8'(a >> 5) ^ (b != 0 ? 8'h3C : 8'hC3);
        cp_write(b[0], a, sh[b][a]);
      end
    cp_read(1'b1, 12'h123, v);
    chk(v == sh[1][12'h123], "R10", "core port readback", v, sh[1][12'h123]);
    cp_read(1'b0, 12'hFFF, v);
    chk(v == sh[0][12'hFFF], "R10", "core port readback top", v, sh[0][12'hFFF]);

    // directed corners
    run_xfer(1, 0, 12'h010, 24'h000100, 0,  0, 0,  0);    // R1 minimum 8 bytes
    run_xfer(1, 1, 12'h200, 24'h001000, 5,  0, 0,  0);    // R1 rounding 5 -> 8
    run_xfer(1, 0, 12'h300, 24'h002000, 8,  2, 4,  0);    // R1 16-byte rows, R2 skip
    run_xfer(1, 1, 12'hFFA, 24'h003000, 7,  2, 3,  0);    // R3 scratchpad wrap
    run_xfer(1, 0, 12'h400, 24'hFFFFF4, 7,  1, 5,  0);    // R2 24-bit wrap
    run_xfer(0, 1, 12'hFFA, 24'h500000, 7,  2, 9,  0);    // outbound with wrap
    run_xfer(0, 0, 12'h010, 24'h510000, 15, 1, 12'hFFF, 0); // R2 maximum skip
    run_xfer(1, 1, 12'h600, 24'h004000, 9,  1, 2,  1);    // R8 inject
    run_xfer(0, 0, 12'h700, 24'h520000, 3,  1, 6,  1);    // R8 inject outbound

    // constrained random
    for (int t = 0; t < 16; t++) begin
      run_xfer($urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
               int'($urandom_range(0, 4095)), int'($urandom_range(0, 24'hFFFFFF)),
               int'($urandom_range(0, 47)), int'($urandom_range(0, 5)),
               int'($urandom_range(0, 63)), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule